// File: doc/BRIEF.md
# Device probe sequence engine

This block decides whether a device answers at its expected register addresses before any driver is attached to it. Software loads a short list of probe steps and a step count, then pulses `start`. The engine walks the list in index order. Each step has a command, an address, an access width, a value and a mask. A write step stores the masked value. A read step fetches a register, masks the returned data and compares it with the value, testing either for equality or for inequality.

All bus traffic goes through a simple master port. The engine holds a request until the target answers with an acknowledge or an error. A failed comparison, a bus error or a missing answer ends the run at once. In that case no later step is issued and the index of the offending step is reported. A run over an empty list finishes immediately and reports the device as present.

A `done` pulse closes every run. `pass`, `err` and `fail_idx` are loaded in the same cycle and hold their values until the next run completes.

Top module: `dev_probe_engine`

## Requirements
- R1: After reset `busy`, `done` and `bus_req` are low, and no bus access is issued until `start` is pulsed.
- R2: Steps run in index order 0 to count−1, one bus access each. Each access carries the step's address and its width code on `bus_size`: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes, with lanes counted from bit 0. The address holds steady while a request waits.
- R3: A write step (command code 0) drives `bus_wdata` = value AND mask AND lane mask, where the lane mask covers the low 1, 2, 4 or 8 bytes selected by the width code.
- R4: A read-equal step (command code 1) passes when (read data AND mask AND lane mask) equals (value AND lane mask).
- R5: A read-not-equal step (command code 2) passes exactly when that same comparison is unequal.
- R6: A failed comparison at step k ends the run: no further access is issued, and `done` comes with `pass`=0, `err`=0 and `fail_idx`=k.
- R7: With a step count of 0, `start` produces `done` on the next clock edge with `pass`=1 and no bus access.
- R8: `bus_err` during step k ends the run with `pass`=0, `err`=1 and `fail_idx`=k, and no later step is issued.
- R9: A request that gets neither acknowledge nor error within TMO_CYC cycles is dropped and ends the run as in R8.
- R10: `done` lasts one cycle. `pass`, `err` and `fail_idx` change only together with `done`, and `fail_idx` is 0 on a passing run. A `start` pulse during a run is ignored.
- R11: A step with command code 3 is skipped. It issues no bus access and counts as passed.
- R12: A step count written above MAX_STEPS is clamped to MAX_STEPS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write one step entry |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_cmd | input | 2 | Step command code |
| cfg_size | input | 2 | Step width code |
| cfg_addr | input | ADDR_W | Step register address |
| cfg_value | input | DATA_W | Step value |
| cfg_mask | input | DATA_W | Step mask |
| cnt_we | input | 1 | Load the step count |
| cnt_in | input | CNT_W | New step count |
| start | input | 1 | Begin a run (pulse) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (one-cycle pulse) |
| pass | output | 1 | Device judged present |
| err | output | 1 | Run ended by bus error or timeout |
| fail_idx | output | IDX_W | Index of the failing step |
| bus_req | output | 1 | Access request, held until answered |
| bus_wr | output | 1 | Access is a write |
| bus_addr | output | ADDR_W | Access address |
| bus_size | output | 2 | Access width code |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Access completed |
| bus_err | input | 1 | Access failed |

## Verification
The bench builds the engine with eight entries, 64-bit data and a 16-cycle timeout. The short timeout keeps hang cases cheap. The eight-entry list lets every abort position, from the first entry to none, be swept in full. All four width codes are crossed with both read tests, with matching and mismatching values, and with garbage above the selected lanes. A bench-side target with per-address error and hang injection sets up the failure paths, and it logs every access so that ordering, early abort and skipped steps are checked at the port.

// File: rtl/probe_pkg.sv
package probe_pkg;

  typedef enum logic [1:0] {
    CMD_WRITE = 2'd0,
    CMD_RD_EQ = 2'd1,
    CMD_RD_NE = 2'd2,
    CMD_SKIP  = 2'd3
  } probe_cmd_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/probe_step_store.sv
module probe_step_store
  import probe_pkg::*;
#(
  parameter int MAX_STEPS = 8,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 64,
  parameter int IDX_W     = 3,
  parameter int CNT_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_cmd,
  input  logic [1:0]        wr_size,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_value,
  input  logic [DATA_W-1:0] wr_mask,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [1:0]        rd_cmd,
  output logic [1:0]        rd_size,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_value,
  output logic [DATA_W-1:0] rd_mask,
  output logic [CNT_W-1:0]  cnt_q
);

  logic [1:0]        cmd_arr   [MAX_STEPS];
  logic [1:0]        size_arr  [MAX_STEPS];
  logic [ADDR_W-1:0] addr_arr  [MAX_STEPS];
  logic [DATA_W-1:0] value_arr [MAX_STEPS];
  logic [DATA_W-1:0] mask_arr  [MAX_STEPS];

  for (genvar e = 0; e < MAX_STEPS; e++) begin : g_entry
    logic              ent_en;
    logic [1:0]        cmd_q;
    logic [1:0]        size_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] value_q;
    logic [DATA_W-1:0] mask_q;

    assign ent_en = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmd_q   <= '0;
        size_q  <= '0;
        addr_q  <= '0;
        value_q <= '0;
        mask_q  <= '0;
      end else if (ent_en) begin
        cmd_q   <= wr_cmd;
        size_q  <= wr_size;
        addr_q  <= wr_addr;
        value_q <= wr_value;
        mask_q  <= wr_mask;
      end
    end

    assign cmd_arr[e]   = cmd_q;
    assign size_arr[e]  = size_q;
    assign addr_arr[e]  = addr_q;
    assign value_arr[e] = value_q;
    assign mask_arr[e]  = mask_q;
  end

  assign rd_cmd   = cmd_arr[rd_idx];
  assign rd_size  = size_arr[rd_idx];
  assign rd_addr  = addr_arr[rd_idx];
  assign rd_value = value_arr[rd_idx];
  assign rd_mask  = mask_arr[rd_idx];

  // count register, clamped on load (R12)
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (cnt_in > CNT_W'(MAX_STEPS)) cnt_d = CNT_W'(MAX_STEPS);
    else                            cnt_d = cnt_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/probe_eval.sv
module probe_eval
  import probe_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [1:0]        cmd,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] wdata,
  output logic              step_ok
);

  localparam int NBYTES = DATA_W / 8;

  logic [NBYTES-1:0] lane_on;
  logic [DATA_W-1:0] lanes;
  logic              rd_match;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign lane_on[b]        = (32'(b) < (32'd1 << size));
    assign lanes[b*8 +: 8]   = {8{lane_on[b]}};
  end

  assign wdata    = value & mask & lanes;
  assign rd_match = ((rdata & mask & lanes) == (value & lanes));

  always_comb begin
    case (cmd)
      CMD_RD_EQ: step_ok = rd_match;
      CMD_RD_NE: step_ok = !rd_match;
      default:   step_ok = 1'b1;
    endcase
  end

endmodule

// File: rtl/probe_seq.sv
module probe_seq
  import probe_pkg::*;
#(
  parameter int IDX_W   = 3,
  parameter int CNT_W   = 4,
  parameter int TMO_CYC = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cnt,
  input  logic [1:0]       cmd,
  input  logic             step_ok,
  input  logic             bus_ack,
  input  logic             bus_err,
  output logic [IDX_W-1:0] idx,
  output logic             bus_req,
  output logic             busy,
  output logic             done,
  output logic             pass,
  output logic             err,
  output logic [IDX_W-1:0] fail_idx
);

  localparam int TMO_W    = $clog2(TMO_CYC + 1);
  localparam int TMO_LAST = TMO_CYC - 1;

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [TMO_W-1:0] tcnt_q, tcnt_d;
  logic             done_q, done_d;
  logic             pass_q, pass_d;
  logic             err_q, err_d;
  logic [IDX_W-1:0] fidx_q, fidx_d;
  logic             res_en;

  logic req, tmo, hard, step_end, step_bad, last;

  assign req      = (state_q == SEQ_RUN) && (cmd != CMD_SKIP);
  assign tmo      = req && (tcnt_q == TMO_W'(TMO_LAST));
  assign hard     = req && (bus_err || tmo);
  assign step_end = (state_q == SEQ_RUN) &&
                    ((cmd == CMD_SKIP) || bus_ack || bus_err || tmo);
  assign step_bad = hard || (req && bus_ack && !step_ok);
  assign last     = ((CNT_W'(idx_q) + CNT_W'(1)) == cnt);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    tcnt_d  = tcnt_q;
    done_d  = 1'b0;
    pass_d  = pass_q;
    err_d   = err_q;
    fidx_d  = fidx_q;
    res_en  = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          if (cnt == '0) begin
            done_d = 1'b1;
            res_en = 1'b1;
            pass_d = 1'b1;
            err_d  = 1'b0;
            fidx_d = '0;
          end else begin
            state_d = SEQ_RUN;
            idx_d   = '0;
            tcnt_d  = '0;
          end
        end
      end
      default: begin
        if (step_end) begin
          tcnt_d = '0;
          if (step_bad) begin
            state_d = SEQ_IDLE;
            done_d  = 1'b1;
            res_en  = 1'b1;
            pass_d  = 1'b0;
            err_d   = hard;
            fidx_d  = idx_q;
          end else if (last) begin
            state_d = SEQ_IDLE;
            done_d  = 1'b1;
            res_en  = 1'b1;
            pass_d  = 1'b1;
            err_d   = 1'b0;
            fidx_d  = '0;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end else if (req) begin
          tcnt_d = tcnt_q + TMO_W'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      tcnt_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      tcnt_q  <= tcnt_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q <= 1'b0;
      err_q  <= 1'b0;
      fidx_q <= '0;
    end else if (res_en) begin
      pass_q <= pass_d;
      err_q  <= err_d;
      fidx_q <= fidx_d;
    end
  end

  assign idx      = idx_q;
  assign bus_req  = req;
  assign busy     = (state_q == SEQ_RUN);
  assign done     = done_q;
  assign pass     = pass_q;
  assign err      = err_q;
  assign fail_idx = fidx_q;

endmodule

// File: rtl/dev_probe_engine.sv
module dev_probe_engine
  import probe_pkg::*;
#(
  parameter  int MAX_STEPS = 8,
  parameter  int ADDR_W    = 16,
  parameter  int DATA_W    = 64,
  parameter  int TMO_CYC   = 256,
  localparam int IDX_W     = (MAX_STEPS > 1) ? $clog2(MAX_STEPS) : 1,
  localparam int CNT_W     = $clog2(MAX_STEPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [1:0]        cfg_cmd,
  input  logic [1:0]        cfg_size,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_value,
  input  logic [DATA_W-1:0] cfg_mask,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              err,
  output logic [IDX_W-1:0]  fail_idx,
  output logic              bus_req,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  input  logic              bus_err
);

  logic [IDX_W-1:0]  cur_idx;
  logic [1:0]        cur_cmd;
  logic [1:0]        cur_size;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_value;
  logic [DATA_W-1:0] cur_mask;
  logic [CNT_W-1:0]  step_cnt;
  logic              cur_ok;

  probe_step_store #(
    .MAX_STEPS(MAX_STEPS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_idx   (cfg_idx),
    .wr_cmd   (cfg_cmd),
    .wr_size  (cfg_size),
    .wr_addr  (cfg_addr),
    .wr_value (cfg_value),
    .wr_mask  (cfg_mask),
    .cnt_we   (cnt_we),
    .cnt_in   (cnt_in),
    .rd_idx   (cur_idx),
    .rd_cmd   (cur_cmd),
    .rd_size  (cur_size),
    .rd_addr  (cur_addr),
    .rd_value (cur_value),
    .rd_mask  (cur_mask),
    .cnt_q    (step_cnt)
  );

  probe_eval #(.DATA_W(DATA_W)) u_eval (
    .cmd     (cur_cmd),
    .size    (cur_size),
    .value   (cur_value),
    .mask    (cur_mask),
    .rdata   (bus_rdata),
    .wdata   (bus_wdata),
    .step_ok (cur_ok)
  );

  probe_seq #(.IDX_W(IDX_W), .CNT_W(CNT_W), .TMO_CYC(TMO_CYC)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cnt      (step_cnt),
    .cmd      (cur_cmd),
    .step_ok  (cur_ok),
    .bus_ack  (bus_ack),
    .bus_err  (bus_err),
    .idx      (cur_idx),
    .bus_req  (bus_req),
    .busy     (busy),
    .done     (done),
    .pass     (pass),
    .err      (err),
    .fail_idx (fail_idx)
  );

  assign bus_wr   = (cur_cmd == CMD_WRITE);
  assign bus_addr = cur_addr;
  assign bus_size = cur_size;

endmodule

// File: rtl/probe_engine_chk.sv
module probe_engine_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic              err,
  input logic              bus_req,
  input logic              bus_ack,
  input logic              bus_err,
  input logic [ADDR_W-1:0] bus_addr
);

  // R2: requests only while a run is active
  p_req_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> busy);

  // R2: a run only begins on a start pulse
  p_run_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R2: address steady while a request waits
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack && !bus_err) |=> (!bus_req || $stable(bus_addr)));

  // R6: a reported result leaves the engine idle, no further access
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !bus_req));

  // R8: an error answer ends the run on the next edge
  p_err_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_err) |=> (done && err && !busy));

  // R8: error never reported as presence
  p_err_nopass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> !pass);

  // R10: done is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: results change only together with done
  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(pass) && $stable(err)));

endmodule

bind dev_probe_engine probe_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .pass     (pass),
  .err      (err),
  .bus_req  (bus_req),
  .bus_ack  (bus_ack),
  .bus_err  (bus_err),
  .bus_addr (bus_addr)
);

// File: tb/dev_probe_engine_tb.sv
module dev_probe_engine_tb;

  localparam int MAX_STEPS = 8;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 64;
  localparam int TMO_CYC   = 16;
  localparam int IDX_W     = 3;
  localparam int CNT_W     = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_we;
  logic [IDX_W-1:0]  cfg_idx;
  logic [1:0]        cfg_cmd, cfg_size;
  logic [ADDR_W-1:0] cfg_addr;
  logic [DATA_W-1:0] cfg_value, cfg_mask;
  logic              cnt_we;
  logic [CNT_W-1:0]  cnt_in;
  logic              start;
  logic              busy, done, pass, err;
  logic [IDX_W-1:0]  fail_idx;
  logic              bus_req, bus_wr;
  logic [ADDR_W-1:0] bus_addr;
  logic [1:0]        bus_size;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic              bus_ack, bus_err;

  always #2.5 clk = ~clk;

  dev_probe_engine #(
    .MAX_STEPS(MAX_STEPS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMO_CYC(TMO_CYC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_cmd(cfg_cmd), .cfg_size(cfg_size),
    .cfg_addr(cfg_addr), .cfg_value(cfg_value), .cfg_mask(cfg_mask),
    .cnt_we(cnt_we), .cnt_in(cnt_in), .start(start),
    .busy(busy), .done(done), .pass(pass), .err(err), .fail_idx(fail_idx),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err)
  );

  int n_vec = 0;
  int n_bad = 0;

  // bench-side target
  logic [DATA_W-1:0] mem [16];
  logic [ADDR_W-1:0] log_addr [32];
  logic [1:0]        log_size [32];
  logic              log_wr   [32];
  int                acc_cnt;
  int                lat;
  int                wcnt;
  logic              err_en, hang_en;
  logic [3:0]        err_addr, hang_addr;
  int                n_done;

  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack = 1'b0;
      bus_err = 1'b0;
      wcnt    = 0;
    end else if (bus_ack || bus_err) begin
      bus_ack = 1'b0;
      bus_err = 1'b0;
      wcnt    = 0;
    end else if (bus_req) begin
      if (hang_en && bus_addr[3:0] == hang_addr) begin
        wcnt = 0;
      end else if (wcnt >= lat) begin
        if (acc_cnt < 32) begin
          log_addr[acc_cnt] = bus_addr;
          log_size[acc_cnt] = bus_size;
          log_wr[acc_cnt]   = bus_wr;
        end
        acc_cnt = acc_cnt + 1;
        if (err_en && bus_addr[3:0] == err_addr) begin
          bus_err = 1'b1;
        end else begin
          bus_ack = 1'b1;
          if (bus_wr) mem[bus_addr[3:0]] = bus_wdata;
          else        bus_rdata = mem[bus_addr[3:0]];
        end
      end else begin
        wcnt = wcnt + 1;
      end
    end else begin
      wcnt = 0;
    end
  end

  always @(negedge clk) if (rst_n && done) n_done = n_done + 1;

  function automatic logic [63:0] lm(input int s);
    if (s == 3) return '1;
    return (64'd1 << (8 << s)) - 64'd1;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic prog(input int i, input logic [1:0] c, input logic [1:0] s,
                      input logic [15:0] a, input logic [63:0] v, input logic [63:0] m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IDX_W'(i); cfg_cmd = c; cfg_size = s;
    cfg_addr = a; cfg_value = v; cfg_mask = m;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_cnt(input int n);
    @(negedge clk);
    cnt_we = 1'b1; cnt_in = CNT_W'(n);
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  // returns negedges waited after start was dropped
  task automatic run(input bit poke, output int cyc);
    acc_cnt = 0;
    n_done  = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 2) start = 1'b1;
      if (poke && cyc == 3) start = 1'b0;
    end
    if (cyc >= 2000) check("watchdog run", 64'd0, 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int cyc;
    logic [63:0] vals [3];
    logic [63:0] msks [3];
    vals[0] = 64'hA5C3_1234_DEAD_BEEF; msks[0] = '1;
    vals[1] = '1;                      msks[1] = 64'h0F0F_F0F0_3C3C_C3C3;
    vals[2] = 64'h1357_9BDF_2468_ACE1; msks[2] = 64'hFFFF_0000_FF00_00FF;

    rst_n = 1'b0; cfg_we = 0; cfg_idx = 0; cfg_cmd = 0; cfg_size = 0;
    cfg_addr = 0; cfg_value = 0; cfg_mask = 0; cnt_we = 0; cnt_in = 0;
    start = 0; bus_rdata = '0; bus_ack = 0; bus_err = 0;
    lat = 1; acc_cnt = 0; n_done = 0; wcnt = 0;
    err_en = 0; hang_en = 0; err_addr = 0; hang_addr = 0;
    for (int i = 0; i < 16; i++) mem[i] = 64'h1111_0000_0000_0000 * 64'(i) + 64'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 done", 64'(done), 64'd0);
    check("R1 bus_req", 64'(bus_req), 64'd0);
    check("R1 no access", 64'(acc_cnt), 64'd0);

    // R7 empty list
    set_cnt(0);
    run(0, cyc);
    check("R7 latency", 64'(cyc), 64'd0);
    check("R7 pass", 64'(pass), 64'd1);
    check("R7 err", 64'(err), 64'd0);
    check("R7 no access", 64'(acc_cnt), 64'd0);

    // R3 write sweep over widths and patterns
    set_cnt(1);
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 3; p++) begin
        mem[5] = 64'h5555_5555_5555_5555;
        prog(0, 2'd0, 2'(s), 16'h0005, vals[p], msks[p]);
        run(0, cyc);
        check("R3 stored data", mem[5], vals[p] & msks[p] & lm(s));
        check("R2 size code", 64'(log_size[0]), 64'(s));
        check("R2 address", 64'(log_addr[0]), 64'h5);
        check("R3 write flag", 64'(log_wr[0]), 64'd1);
        check("R3 pass", 64'(pass), 64'd1);
      end
    end

    // R4/R5 read sweep: widths x test x match/mismatch/upper garbage
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 3; p++) begin
        for (int c = 1; c <= 2; c++) begin
          for (int mode = 0; mode < 3; mode++) begin
            logic [63:0] v;
            logic        eq;
            mem[3] = vals[(p + 1) % 3] ^ 64'h00F0_0F00_F000_000F;
            v = mem[3] & msks[p] & lm(s);
            if (mode == 1) v = v ^ 64'd1;
            if (mode == 2) v = v | (~lm(s) & 64'hDEAD_BEEF_CAFE_F00D);
            prog(0, 2'(c), 2'(s), 16'h0003, v, msks[p]);
            run(0, cyc);
            eq = ((mem[3] & msks[p] & lm(s)) == (v & lm(s)));
            if (c == 1) check("R4 read-equal verdict", 64'(pass), 64'(eq));
            else        check("R5 read-not-equal verdict", 64'(pass), 64'(!eq));
            check("R4 R5 err clear", 64'(err), 64'd0);
          end
        end
      end
    end

    // R2/R6 abort position sweep over eight reads
    for (int i = 0; i < 16; i++) mem[i] = 64'h0123_4567_89AB_CDEF + 64'(i * 7);
    set_cnt(8);
    for (int k = 0; k <= 8; k++) begin
      for (int i = 0; i < 8; i++)
        prog(i, 2'd1, 2'd3, 16'(i), (i == k) ? ~mem[i] : mem[i], '1);
      run(0, cyc);
      check("R6 pass", 64'(pass), 64'(k == 8));
      check("R6 err", 64'(err), 64'd0);
      check("R6 fail index", 64'(fail_idx), (k < 8) ? 64'(k) : 64'd0);
      check("R6 access count", 64'(acc_cnt), (k < 8) ? 64'(k + 1) : 64'd8);
      for (int i = 0; i < acc_cnt && i < 8; i++)
        check("R2 order", 64'(log_addr[i]), 64'(i));
    end

    // R2 typical: write zero to reg 0, then bit 0 of reg 7 must be clear
    set_cnt(2);
    prog(0, 2'd0, 2'd2, 16'h0000, 64'd0, '1);
    prog(1, 2'd1, 2'd2, 16'h0007, 64'd0, 64'd1);
    mem[0] = '1; mem[7] = 64'hFFFF_FFFE;
    run(0, cyc);
    check("R2 reset written", mem[0], 64'd0);
    check("R4 status clear pass", 64'(pass), 64'd1);
    mem[7] = 64'h0000_0001;
    run(0, cyc);
    check("R4 status set fail", 64'(pass), 64'd0);
    check("R6 status fail index", 64'(fail_idx), 64'd1);

    // R8 bus error at each position
    for (int i = 0; i < 4; i++) prog(i, 2'd1, 2'd3, 16'(i), mem[i], '1);
    set_cnt(4);
    for (int k = 0; k < 4; k++) begin
      err_en = 1; err_addr = 4'(k);
      run(0, cyc);
      check("R8 err", 64'(err), 64'd1);
      check("R8 pass", 64'(pass), 64'd0);
      check("R8 fail index", 64'(fail_idx), 64'(k));
      check("R8 access count", 64'(acc_cnt), 64'(k + 1));
    end
    err_en = 0;

    // R9 timeout on step 1
    set_cnt(3);
    hang_en = 1; hang_addr = 4'd1;
    run(0, cyc);
    check("R9 err", 64'(err), 64'd1);
    check("R9 pass", 64'(pass), 64'd0);
    check("R9 fail index", 64'(fail_idx), 64'd1);
    check("R9 waited at least timeout", 64'(cyc >= TMO_CYC), 64'd1);
    check("R9 access count", 64'(acc_cnt), 64'd1);
    @(negedge clk);
    check("R9 request dropped", 64'(bus_req), 64'd0);
    hang_en = 0;

    // R10 start during run ignored, done single cycle, results held
    lat = 5;
    set_cnt(2);
    run(1, cyc);
    check("R10 pass", 64'(pass), 64'd1);
    check("R10 fail index zero on pass", 64'(fail_idx), 64'd0);
    @(negedge clk);
    check("R10 done one cycle", 64'(done), 64'd0);
    repeat (20) @(negedge clk);
    check("R10 single done", 64'(n_done), 64'd1);
    check("R10 no restart accesses", 64'(acc_cnt), 64'd2);
    check("R10 result held", 64'(pass), 64'd1);
    check("R10 idle", 64'(busy), 64'd0);
    lat = 1;

    // R11 skip steps
    set_cnt(3);
    prog(0, 2'd3, 2'd0, 16'h0009, '1, '1);
    prog(1, 2'd0, 2'd1, 16'h000A, 64'h1234, '1);
    prog(2, 2'd3, 2'd0, 16'h000B, '1, '1);
    run(0, cyc);
    check("R11 pass", 64'(pass), 64'd1);
    check("R11 access count", 64'(acc_cnt), 64'd1);
    check("R11 address", 64'(log_addr[0]), 64'hA);

    // R12 count clamp
    for (int i = 0; i < 8; i++) prog(i, 2'd0, 2'd0, 16'(i), 64'd0, '1);
    set_cnt(15);
    run(0, cyc);
    check("R12 clamp 15", 64'(acc_cnt), 64'd8);
    set_cnt(9);
    run(0, cyc);
    check("R12 clamp 9", 64'(acc_cnt), 64'd8);
    check("R12 pass", 64'(pass), 64'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule